// File: doc/BRIEF.md
# Display Plane Compositor

The compositor sits in the scan-out path and runs once for every displayed pixel. Each pixel brings its stored plane values: two 24-bit image banks, two 8-bit overlay banks, a 10-bit window identifier, eight fast-clear bits, and the cursor enable and cursor data bits. The compositor picks one value and a destination table, and sends them toward the colour converters. Pixels are marked by a pixel-valid strobe from the video timing logic, which lies outside this block.

The decision follows a fixed order:

1. The cursor wins whenever it is enabled.
2. Otherwise a per-window entry, looked up by the window identifier, decides between overlay and image and between true-colour and indexed output.
3. The entry also picks the displayed bank and the fast-clear plane. A pixel whose fast-clear bit is clear shows a programmable background colour.

The global front-buffer flag changes only when a latched swap request meets a vertical-blank pulse. It is held by a two-state machine:

- SW_SHOWING is the idle state. A swap request moves it to SW_ARMED.
- In SW_ARMED, a vblank pulse toggles the front flag. The machine then returns to SW_SHOWING, or stays armed if a new request arrives in that same cycle.

The window table and the background register are written through a simple register port.

Top module: `plane_compositor`

## Requirements
- R1: When cursor enable is 1 the output tag is CURSOR (2) with table 0, whatever the window entry, plane values and fast-clear bits are.
- R2: For a cursor pixel, out_data[0] equals the cursor data bit and out_data[23:1] are zero.
- R3: A write with cfg_we=1 and cfg_bg=0 stores cfg_wdata[8:0] as the window entry at cfg_addr. The entry fields are: bit 0 overlay select, bit 1 true-colour mode, bits 5:2 table number, bit 6 buffer select, bits 8:7 fast-clear plane number.
- R4: With overlay select set, the output tag is INDEX (1), out_data[7:0] is the chosen overlay byte with the upper bits zero, and out_table is the entry's table number.
- R5: With image selected and true-colour clear, the output tag is INDEX (1) with the low byte of the chosen image bank. The table number is saturated so that 14 and 15 give 13.
- R6: With image selected and true-colour set, the output tag is TRUE (0) and out_data is the full 24-bit chosen image bank, with table 0.
- R7: The displayed bank is the front flag XOR the entry's buffer select. Bank 0 is A and bank 1 is B.
- R8: The fast-clear bit used is fc_bits[2*plane + bank]. When that bit is 0 (and the cursor is off), the output is tag TRUE, table 0, with the background register as data. A write with cfg_we=1 and cfg_bg=1 loads that register from cfg_wdata.
- R9: A swap request is latched, and the front flag toggles at the first vblank pulse in a later cycle. A vblank with no pending request changes nothing, and a request in the same cycle as a vblank waits for the next vblank.
- R10: out_valid rises exactly two clock cycles after pix_valid and is low two cycles after a cycle with pix_valid low.
- R11: After reset the front flag is 0, every window entry is 0, the background is 0, no swap is pending and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Plane inputs hold a displayed pixel this cycle |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| swap_req | input | 1 | Request a front/back buffer exchange |
| img_a | input | 24 | Image bank A value |
| img_b | input | 24 | Image bank B value |
| ovl_a | input | 8 | Overlay bank A value |
| ovl_b | input | 8 | Overlay bank B value |
| wid | input | 10 | Window identifier of the pixel |
| fc_bits | input | 8 | Fast-clear bits, index 2*plane+bank |
| cur_en | input | 1 | Cursor enable plane |
| cur_data | input | 1 | Cursor colour plane |
| cfg_we | input | 1 | Register port write strobe |
| cfg_bg | input | 1 | 1 selects background register, 0 the window table |
| cfg_addr | input | 10 | Window table address |
| cfg_wdata | input | 24 | Write data |
| out_valid | output | 1 | Output pixel valid |
| out_kind | output | 2 | 0 true colour, 1 indexed, 2 cursor |
| out_table | output | 4 | Indexed table number (0 to 13) |
| out_data | output | 24 | Colour value or table index |

## Verification
The assertions assume that vblank is a single-cycle pulse and that every input is stable across the sampling edge. They also assume that table writes do not target a window while one of its pixels is in the first pipeline stage. The latency properties further assume that pix_valid is a known value in every cycle after reset. The bench drives all inputs on the falling edge and holds them for a full cycle. It pulses vblank and swap_req for one cycle each, and performs configuration writes only while no pixel is in flight.

// File: rtl/pc_pkg.sv
package pc_pkg;
    localparam int CLUT_W   = 4;
    localparam int MAX_CLUT = 13;
    localparam int FC_N     = 4;
    localparam int FCP_W    = $clog2(FC_N);
    localparam int FC_BITS  = 2 * FC_N;

    typedef enum logic [1:0] {
        K_TRUE   = 2'd0,
        K_INDEX  = 2'd1,
        K_CURSOR = 2'd2
    } kind_e;

    typedef struct packed {
        logic [FCP_W-1:0]  fc_plane;
        logic              buf_sel;
        logic [CLUT_W-1:0] clut;
        logic              true_col;
        logic              ovl_sel;
    } went_t;

    localparam int ENT_W = $bits(went_t);
endpackage

// File: rtl/pc_wlut.sv
module pc_wlut
    import pc_pkg::*;
#(
    parameter int WID_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WID_W-1:0] waddr,
    input  went_t            wdata,
    input  logic [WID_W-1:0] raddr,
    output went_t            rdata
);
    localparam int DEPTH = 1 << WID_W;

    went_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pc_swap_fsm.sv
module pc_swap_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic vblank,
    output logic front
);
    typedef enum logic {
        SW_SHOWING = 1'b0,
        SW_ARMED   = 1'b1
    } swap_st_e;

    swap_st_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_SHOWING;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SW_SHOWING: if (swap_req) state_nxt = SW_ARMED;
            SW_ARMED:   if (vblank && !swap_req) state_nxt = SW_SHOWING;
            default:    state_nxt = SW_SHOWING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           front <= 1'b0;
        else if (state == SW_ARMED && vblank) front <= ~front;
    end

    // R9: the front flag only moves in the cycle after a vblank pulse
    p_swap_only_vblank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (front != $past(front)) |-> $past(vblank));

    // R9: no pending request means the displayed buffer holds
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_SHOWING) |=> $stable(front));
endmodule

// File: rtl/pc_select.sv
module pc_select
    import pc_pkg::*;
#(
    parameter int IMG_W = 24,
    parameter int OVL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [IMG_W-1:0]   img_a,
    input  logic [IMG_W-1:0]   img_b,
    input  logic [OVL_W-1:0]   ovl_a,
    input  logic [OVL_W-1:0]   ovl_b,
    input  logic [FC_BITS-1:0] fc_bits,
    input  logic               cur_en,
    input  logic               cur_data,
    input  went_t              entry,
    input  logic               front,
    input  logic [IMG_W-1:0]   bg_colour,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [CLUT_W-1:0]  out_table,
    output logic [IMG_W-1:0]   out_data
);
    typedef enum logic [2:0] {
        P_CURSOR, P_BLANK, P_OVL, P_IMG_IDX, P_IMG_TRUE
    } path_e;

    // stage 1: captured planes and window properties
    logic               s1_valid;
    logic [IMG_W-1:0]   s1_img_a, s1_img_b;
    logic [OVL_W-1:0]   s1_ovl_a, s1_ovl_b;
    logic [FC_BITS-1:0] s1_fc;
    logic               s1_cur_en, s1_cur_data;
    went_t              s1_ent;
    logic               s1_front;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_img_a    <= '0;
            s1_img_b    <= '0;
            s1_ovl_a    <= '0;
            s1_ovl_b    <= '0;
            s1_fc       <= '0;
            s1_cur_en   <= 1'b0;
            s1_cur_data <= 1'b0;
            s1_ent      <= '0;
            s1_front    <= 1'b0;
        end else begin
            s1_valid <= pix_valid;
            if (pix_valid) begin
                s1_img_a    <= img_a;
                s1_img_b    <= img_b;
                s1_ovl_a    <= ovl_a;
                s1_ovl_b    <= ovl_b;
                s1_fc       <= fc_bits;
                s1_cur_en   <= cur_en;
                s1_cur_data <= cur_data;
                s1_ent      <= entry;
                s1_front    <= front;
            end
        end
    end

    // stage 2 decision
    logic              bank;
    logic [FCP_W:0]    fc_idx;
    logic              fc_ok;
    logic [CLUT_W-1:0] clut_sat;
    logic [IMG_W-1:0]  img_pick;
    logic [OVL_W-1:0]  ovl_pick;
    path_e             path;

    always_comb begin
        bank     = s1_front ^ s1_ent.buf_sel;
        fc_idx   = {s1_ent.fc_plane, bank};
        fc_ok    = s1_fc[fc_idx];
        clut_sat = (s1_ent.clut > CLUT_W'(MAX_CLUT)) ? CLUT_W'(MAX_CLUT) : s1_ent.clut;
        img_pick = bank ? s1_img_b : s1_img_a;
        ovl_pick = bank ? s1_ovl_b : s1_ovl_a;
        if (s1_cur_en)              path = P_CURSOR;
        else if (!fc_ok)            path = P_BLANK;
        else if (s1_ent.ovl_sel)    path = P_OVL;
        else if (s1_ent.true_col)   path = P_IMG_TRUE;
        else                        path = P_IMG_IDX;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= K_TRUE;
            out_table <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                unique case (path)
                    P_CURSOR: begin
                        out_kind  <= K_CURSOR;
                        out_table <= '0;
                        out_data  <= IMG_W'(s1_cur_data);
                    end
                    P_BLANK: begin
                        out_kind  <= K_TRUE;
                        out_table <= '0;
                        out_data  <= bg_colour;
                    end
                    P_OVL: begin
                        out_kind  <= K_INDEX;
                        out_table <= clut_sat;
                        out_data  <= IMG_W'(ovl_pick);
                    end
                    P_IMG_IDX: begin
                        out_kind  <= K_INDEX;
                        out_table <= clut_sat;
                        out_data  <= IMG_W'(img_pick[OVL_W-1:0]);
                    end
                    P_IMG_TRUE: begin
                        out_kind  <= K_TRUE;
                        out_table <= '0;
                        out_data  <= img_pick;
                    end
                    default: begin
                        out_kind  <= K_TRUE;
                        out_table <= '0;
                        out_data  <= '0;
                    end
                endcase
            end
        end
    end

    // R10: fixed two-cycle latency
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ##1 !out_valid);
    // R1: cursor overrides every other plane
    p_cursor_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_cur_en) |=> (out_valid && out_kind == K_CURSOR));
    // R2: cursor colour is a single bit
    p_cursor_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_CURSOR) |-> (out_data[IMG_W-1:1] == '0));
    // R5: only 14 indexed tables exist
    p_table_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_INDEX) |-> (out_table <= CLUT_W'(MAX_CLUT)));
endmodule

// File: rtl/plane_compositor.sv
module plane_compositor
    import pc_pkg::*;
#(
    parameter int WID_W = 10,
    parameter int IMG_W = 24,
    parameter int OVL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               vblank,
    input  logic               swap_req,
    input  logic [IMG_W-1:0]   img_a,
    input  logic [IMG_W-1:0]   img_b,
    input  logic [OVL_W-1:0]   ovl_a,
    input  logic [OVL_W-1:0]   ovl_b,
    input  logic [WID_W-1:0]   wid,
    input  logic [FC_BITS-1:0] fc_bits,
    input  logic               cur_en,
    input  logic               cur_data,
    input  logic               cfg_we,
    input  logic               cfg_bg,
    input  logic [WID_W-1:0]   cfg_addr,
    input  logic [IMG_W-1:0]   cfg_wdata,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [CLUT_W-1:0]  out_table,
    output logic [IMG_W-1:0]   out_data
);
    went_t            entry;
    logic             front;
    logic [IMG_W-1:0] bg_colour;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bg_colour <= '0;
        else if (cfg_we && cfg_bg) bg_colour <= cfg_wdata;
    end

    pc_wlut #(.WID_W(WID_W)) u_wlut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && !cfg_bg),
        .waddr (cfg_addr),
        .wdata (went_t'(cfg_wdata[ENT_W-1:0])),
        .raddr (wid),
        .rdata (entry)
    );

    pc_swap_fsm u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (swap_req),
        .vblank   (vblank),
        .front    (front)
    );

    pc_select #(.IMG_W(IMG_W), .OVL_W(OVL_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .img_a     (img_a),
        .img_b     (img_b),
        .ovl_a     (ovl_a),
        .ovl_b     (ovl_b),
        .fc_bits   (fc_bits),
        .cur_en    (cur_en),
        .cur_data  (cur_data),
        .entry     (entry),
        .front     (front),
        .bg_colour (bg_colour),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_table (out_table),
        .out_data  (out_data)
    );
endmodule

// File: tb/plane_compositor_tb.sv
module plane_compositor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 0, vblank = 0, swap_req = 0;
    logic [23:0] img_a = 0, img_b = 0;
    logic [7:0]  ovl_a = 0, ovl_b = 0, fc_bits = 0;
    logic [9:0]  wid = 0, cfg_addr = 0;
    logic        cur_en = 0, cur_data = 0, cfg_we = 0, cfg_bg = 0;
    logic [23:0] cfg_wdata = 0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [3:0]  out_table;
    logic [23:0] out_data;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    plane_compositor u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .vblank(vblank),
        .swap_req(swap_req), .img_a(img_a), .img_b(img_b), .ovl_a(ovl_a),
        .ovl_b(ovl_b), .wid(wid), .fc_bits(fc_bits), .cur_en(cur_en),
        .cur_data(cur_data), .cfg_we(cfg_we), .cfg_bg(cfg_bg),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_kind(out_kind), .out_table(out_table), .out_data(out_data)
    );

    function automatic logic [8:0] mk(input logic ovl, input logic tc,
        input logic [3:0] clut, input logic bsel, input logic [1:0] fcp);
        return {fcp, bsel, clut, tc, ovl};
    endfunction

    function automatic logic [31:0] ex(input logic [1:0] k, input logic [3:0] t,
        input logic [23:0] d);
        return {2'b00, k, t, d};
    endfunction

    typedef struct packed {
        logic [8:0]  ent;
        logic [23:0] ia, ib;
        logic [7:0]  oa, ob, fc;
        logic        ce, cd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R6: true colour from bank A
        '{mk(0,1,4'd0,0,2'd0), 24'hAABBCC, 24'h112233, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, ex(2'd0,4'd0,24'hAABBCC)},
        // R7: buffer select picks bank B
        '{mk(0,1,4'd0,1,2'd0), 24'hAABBCC, 24'h112233, 8'h00, 8'h00, 8'h02, 1'b0, 1'b0, ex(2'd0,4'd0,24'h112233)},
        // R5: indexed image, table 5
        '{mk(0,0,4'd5,0,2'd0), 24'h00157E, 24'h0000FF, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, ex(2'd1,4'd5,24'h00007E)},
        // R5: table 15 saturates to 13
        '{mk(0,0,4'd15,0,2'd0), 24'h000033, 24'h0, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, ex(2'd1,4'd13,24'h000033)},
        // R4: overlay bank B, fast-clear plane 2
        '{mk(1,0,4'd3,1,2'd2), 24'h123456, 24'h654321, 8'h11, 8'h44, 8'h20, 1'b0, 1'b0, ex(2'd1,4'd3,24'h000044)},
        // R8: plane 3 bank 0 bit clear -> background
        '{mk(0,1,4'd0,0,2'd3), 24'hFFFFFF, 24'hEEEEEE, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0, ex(2'd0,4'd0,24'h123456)},
        // R1/R2: cursor beats fast-clear and overlay
        '{mk(1,0,4'd7,0,2'd0), 24'hFFFFFF, 24'h0, 8'h99, 8'h00, 8'h00, 1'b1, 1'b1, ex(2'd2,4'd0,24'h000001)},
        // R2: cursor data 0
        '{mk(0,1,4'd0,0,2'd0), 24'hFFFFFF, 24'h0, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, ex(2'd2,4'd0,24'h000000)}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic bg, input logic [9:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_bg = bg; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0; cfg_bg = 0;
    endtask

    // drive one pixel and return the composed output after two edges
    task automatic pixel(input logic [9:0] w, input logic [23:0] ia, input logic [23:0] ib,
        input logic [7:0] oa, input logic [7:0] ob, input logic [7:0] fc,
        input logic ce, input logic cd, output logic [31:0] res, output logic v1);
        @(negedge clk);
        pix_valid = 1; wid = w; img_a = ia; img_b = ib; ovl_a = oa; ovl_b = ob;
        fc_bits = fc; cur_en = ce; cur_data = cd;
        @(negedge clk);
        pix_valid = 0;
        v1 = out_valid;
        @(negedge clk);
        res = {out_valid, 1'b0, out_kind, out_table, out_data};
    endtask

    task automatic pulse_swap(); @(negedge clk); swap_req = 1; @(negedge clk); swap_req = 0; endtask
    task automatic pulse_vb();   @(negedge clk); vblank = 1;   @(negedge clk); vblank = 0;   endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic        v1;
        repeat (3) @(negedge clk);
        // R11: reset state at the port
        chk("R11 out_valid after reset", {31'b0, out_valid}, 32'd0);
        rst_n = 1;
        // R11: default entry 0 (indexed image, table 0, plane 0), background 0
        pixel(10'd0, 24'h0000AB, 24'h0, 0, 0, 8'h01, 0, 0, r, v1);
        chk("R11 default entry", r, {1'b1, 1'b0, 2'd1, 4'd0, 24'h0000AB});
        pixel(10'd0, 24'h0000AB, 24'h0, 0, 0, 8'h00, 0, 0, r, v1);
        chk("R11 background resets to 0", r, {1'b1, 1'b0, 2'd0, 4'd0, 24'h0});

        // R8/R3: program background and window entries
        cfg_write(1'b1, 10'd0, 24'h123456);
        for (int i = 0; i < NV; i++) begin
            cfg_write(1'b0, 10'(i + 1), {15'b0, VECS[i].ent});
        end
        for (int i = 0; i < NV; i++) begin
            pixel(10'(i + 1), VECS[i].ia, VECS[i].ib, VECS[i].oa, VECS[i].ob,
                  VECS[i].fc, VECS[i].ce, VECS[i].cd, r, v1);
            chk($sformatf("R3 vector %0d", i), r, {1'b1, 1'b0, VECS[i].exp[29:0]});
        end

        // R10: latency, and no output for idle cycles
        pixel(10'd1, 24'h010203, 24'h0, 0, 0, 8'h01, 0, 0, r, v1);
        chk("R10 not valid after one cycle", {31'b0, v1}, 32'd0);
        chk("R10 valid after two cycles", {31'b0, r[31]}, 32'd1);
        @(negedge clk); @(negedge clk);
        chk("R10 idle pix_valid gives no output", {31'b0, out_valid}, 32'd0);

        // R9: vblank alone does not swap (window 1: true colour, buf 0)
        pulse_vb();
        pixel(10'd1, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R9 vblank without request", {8'b0, r[23:0]}, 32'hA0A0A0);
        // R9: request then vblank swaps to B; request alone does not
        pulse_swap();
        pixel(10'd1, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R9 pending request waits for vblank", {8'b0, r[23:0]}, 32'hA0A0A0);
        pulse_vb();
        pixel(10'd1, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R9 swap at vblank", {8'b0, r[23:0]}, 32'hB0B0B0);
        // R7: front 1 XOR buf 1 gives bank A (window 2)
        pixel(10'd2, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R7 front xor buffer select", {8'b0, r[23:0]}, 32'hA0A0A0);
        // R9: request coinciding with vblank waits for the next one
        @(negedge clk); swap_req = 1; vblank = 1;
        @(negedge clk); swap_req = 0; vblank = 0;
        pixel(10'd1, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R9 same-cycle request not applied", {8'b0, r[23:0]}, 32'hB0B0B0);
        pulse_vb();
        pixel(10'd1, 24'hA0A0A0, 24'hB0B0B0, 0, 0, 8'h03, 0, 0, r, v1);
        chk("R9 applied at next vblank", {8'b0, r[23:0]}, 32'hA0A0A0);

        // R1: cursor wins over a blanked window
        pixel(10'd6, 24'h0, 24'h0, 0, 0, 8'h00, 1, 1, r, v1);
        chk("R1 cursor over background", r, {1'b1, 1'b0, 2'd2, 4'd0, 24'h000001});
        finish_run();
    end
endmodule